// File: doc/BRIEF.md
# Two-Phase Oscillator Pulse-Count Guard

This block supervises a relaxation oscillator in which each comparator has to fire twice in every oscillator period: once at the end of a pre-charge and once at the end of the timed charge. Each comparator pulse train is halved by a toggle stage, and the halved level is inspected on every falling edge of the oscillator clock. While both pulses arrive, that level is the same at every inspection and reads high. If a pulse is lost, because of a supply disturbance, a corrupted control state or a trim setting that makes the period too short for both charge phases, the level reads low and the block drives the oscillator back into a known start-up state.

Recovery uses three active-low resets. One removes the reference and comparator bias. One disables the charging current. One forces the oscillator output clock low. All three assert together. They stay asserted for a programmable number of cycles of a free-running supervisor clock. They are then released one at a time, bias first and clock last, with a fixed gap between steps. The halving stages are cleared while any reset is active, so detection starts from a known phase.

During frequency trimming, each reset event means that the trial setting is too fast. A sticky flag for each comparator and a saturating event counter are brought out so that a trim sequencer can read the result.

Top module: `osc_pulse_guard`

## Requirements
- R1: While `rst_n` is low at a `clk` edge, all three reset outputs are 0, `fault_seen_o` is 0 and `fault_count_o` is 0. After `rst_n` returns high, the same hold-and-release timing as in R4 and R5 runs.
- R2: Each comparator input is halved by a stage that toggles on every rising edge of that input. When every comparator gives two pulses in each oscillator period, no reset output falls.
- R3: The halved level of each comparator is inspected at each falling edge of `osc_clk_i`. If that level is low, a fault is raised. Losing either pulse of either comparator therefore causes a fault within two oscillator periods. At a fault, all three reset outputs go low on the same `clk` edge.
- R4: After a fault, or after `rst_n` is released, `rst_bias_n_o` stays low for max(`hold_len_i`, 1) `clk` cycles.
- R5: Release order is fixed: `rst_bias_n_o` rises first, `rst_chg_n_o` rises GAP_CYCLES (default 4) cycles later, and `rst_clk_n_o` rises GAP_CYCLES cycles after that.
- R6: Fault detection is enabled only while all three resets are released. The halving stages are forced to 0 whenever detection is disabled, so restarting the oscillator never raises a false fault.
- R7: `fault_seen_o` bit 0 belongs to comparator input 0 and bit 1 to comparator input 1. A bit is set by a fault from its comparator and is cleared only by `rst_n`.
- R8: `fault_count_o` increases by one for each fault event, including events where both comparators fault together. It holds at 2^CNT_W-1 (default 15).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running supervisor clock, much faster than the oscillator |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_clk_i | input | 1 | Oscillator output clock (asynchronous) |
| cmp_i | input | NUM_CMP | Comparator output pulse trains (asynchronous) |
| hold_len_i | input | HOLD_W | Minimum reset hold length in `clk` cycles (0 treated as 1) |
| rst_bias_n_o | output | 1 | Active-low reset for reference and comparator bias |
| rst_chg_n_o | output | 1 | Active-low reset for the charging circuit |
| rst_clk_n_o | output | 1 | Active-low hold of the oscillator output clock |
| fault_seen_o | output | NUM_CMP | Sticky fault flag per comparator |
| fault_count_o | output | CNT_W | Saturating count of fault events |

## Verification
The assertions assume that the supervisor clock oversamples the oscillator. Every comparator pulse and every oscillator phase must be at least two `clk` periods long, and a comparator rising edge must never reach the synchronizer output in the same cycle as an oscillator falling edge. They also assume that `hold_len_i` does not change while a hold is running, and that the oscillator stays silent while `rst_clk_n_o` is low. The bench oscillator places pulses two `clk` periods wide at fixed slots that are at least two cycles away from the falling edge. It changes `hold_len_i` only while all resets are released, and it stops driving pulses as soon as it sees the clock-hold reset.

// File: rtl/opg_pkg.sv
// Package: types shared by the pulse guard modules.
// Assumes nothing beyond IEEE 1800-2017.
package opg_pkg;

    // Recovery sequencer states, in release order.
    typedef enum logic [1:0] {
        SEQ_HOLD    = 2'd0,
        SEQ_BIAS_UP = 2'd1,
        SEQ_CHG_UP  = 2'd2,
        SEQ_RUN     = 2'd3
    } seq_state_t;

endpackage

// File: rtl/opg_edge_sync.sv
// opg_edge_sync: brings an asynchronous level into the clk domain through
// STAGES flops and emits a one-cycle strobe on the chosen edge.
// Assumes the level stays stable for at least two clk periods per phase.
module opg_edge_sync #(
    parameter int STAGES      = 2,
    parameter bit DETECT_FALL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic edge_o
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Purpose: shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], d_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    // Purpose: pick the rising or falling variant of the edge strobe.
    generate
        if (DETECT_FALL) begin : g_fall
            assign edge_o = last_q & ~sync_q[STAGES-1];
        end else begin : g_rise
            assign edge_o = ~last_q & sync_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/opg_pulse_check.sv
// opg_pulse_check: halves one comparator pulse train and inspects the halved
// level at each oscillator falling edge; a low level flags a lost pulse.
// Assumes cmp_rise_i and osc_fall_i never coincide in one cycle.
module opg_pulse_check (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic cmp_rise_i,
    input  logic osc_fall_i,
    output logic fault_o
);

    logic half_q;

    // Purpose: toggle on each comparator pulse, cleared while detection is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            half_q <= 1'b0;
        end else if (cmp_rise_i) begin
            half_q <= ~half_q;
        end
    end

    // Purpose: the inspection at the inverted oscillator clock edge.
    assign fault_o = en_i & osc_fall_i & ~half_q;

    // R6: once detection switches off, the halving stage is cleared next cycle.
    a_r6_half_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !half_q);

endmodule

// File: rtl/opg_rst_seq.sv
// opg_rst_seq: holds the three oscillator resets after a fault and releases
// them in order, bias first and clock last.
// Assumes hold_len_i is stable while a hold is in progress.
module opg_rst_seq
    import opg_pkg::*;
#(
    parameter int HOLD_W     = 8,
    parameter int GAP_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_i,
    input  logic [HOLD_W-1:0] hold_len_i,
    output logic              rst_bias_n_o,
    output logic              rst_chg_n_o,
    output logic              rst_clk_n_o,
    output logic              run_o
);

    localparam int GAP_W = $clog2(GAP_CYCLES + 1);
    localparam int CW    = (HOLD_W > GAP_W) ? HOLD_W : GAP_W;
    localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYCLES - 1);

    seq_state_t  state_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] hold_ext;

    // Purpose: a hold length of zero is treated as one cycle.
    always_comb begin
        hold_ext = CW'(hold_len_i);
        if (hold_len_i == '0) begin
            hold_ext = CW'(1);
        end
    end

    // Purpose: state and shared step counter of the recovery sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_HOLD;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SEQ_RUN: begin
                    if (fault_i) begin
                        state_q <= SEQ_HOLD;
                        cnt_q   <= '0;
                    end
                end
                SEQ_HOLD: begin
                    if (cnt_q >= hold_ext - CW'(1)) begin
                        state_q <= SEQ_BIAS_UP;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                SEQ_BIAS_UP: begin
                    if (cnt_q == GAP_LAST) begin
                        state_q <= SEQ_CHG_UP;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                SEQ_CHG_UP: begin
                    if (cnt_q == GAP_LAST) begin
                        state_q <= SEQ_RUN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                default: begin
                    state_q <= SEQ_HOLD;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // Purpose: decode the staged reset outputs from the sequencer state.
    assign rst_bias_n_o = (state_q != SEQ_HOLD);
    assign rst_chg_n_o  = (state_q == SEQ_CHG_UP) || (state_q == SEQ_RUN);
    assign rst_clk_n_o  = (state_q == SEQ_RUN);
    assign run_o        = rst_clk_n_o;

    // Purpose: checker-only count of consecutive cycles with bias reset low.
    logic [CW:0] low_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n || rst_bias_n_o) begin
            low_run_q <= '0;
        end else if (low_run_q != '1) begin
            low_run_q <= low_run_q + 1'b1;
        end
    end

    a_r3_fault_drops_all: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && fault_i) |=> (!rst_bias_n_o && !rst_chg_n_o && !rst_clk_n_o));
    a_r4_hold_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_bias_n_o) |-> (low_run_q >= {1'b0, hold_ext}));
    a_r5_chg_after_bias: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_chg_n_o) |-> $past(rst_bias_n_o));
    a_r5_clk_after_chg: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_clk_n_o) |-> $past(rst_chg_n_o));

endmodule

// File: rtl/opg_fault_log.sv
// opg_fault_log: sticky per-comparator fault flags and a saturating count of
// fault events for the trim sequencer.
// Assumes fault_vec_i is already gated to the running state.
module opg_fault_log #(
    parameter int NUM_CMP = 2,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CMP-1:0] fault_vec_i,
    output logic [NUM_CMP-1:0] fault_seen_o,
    output logic [CNT_W-1:0]   fault_count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Purpose: accumulate sticky flags and count events up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_seen_o  <= '0;
            fault_count_o <= '0;
        end else begin
            fault_seen_o <= fault_seen_o | fault_vec_i;
            if ((|fault_vec_i) && (fault_count_o != CNT_MAX)) begin
                fault_count_o <= fault_count_o + 1'b1;
            end
        end
    end

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_seen_o & $past(fault_seen_o)) == $past(fault_seen_o));
    a_r8_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        fault_count_o >= $past(fault_count_o));
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_count_o == CNT_MAX) |=> (fault_count_o == CNT_MAX));

endmodule

// File: rtl/osc_pulse_guard.sv
// osc_pulse_guard: top of the two-phase oscillator pulse-count guard.
// Oversamples the oscillator clock and comparator outputs in the clk domain,
// detects a lost comparator pulse, and sequences the recovery resets.
// Assumes clk is fast enough that every input phase spans two clk periods.
module osc_pulse_guard #(
    parameter int NUM_CMP     = 2,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_W      = 8,
    parameter int GAP_CYCLES  = 4,
    parameter int CNT_W       = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               osc_clk_i,
    input  logic [NUM_CMP-1:0] cmp_i,
    input  logic [HOLD_W-1:0]  hold_len_i,
    output logic               rst_bias_n_o,
    output logic               rst_chg_n_o,
    output logic               rst_clk_n_o,
    output logic [NUM_CMP-1:0] fault_seen_o,
    output logic [CNT_W-1:0]   fault_count_o
);

    logic               osc_fall;
    logic [NUM_CMP-1:0] cmp_rise;
    logic [NUM_CMP-1:0] fault_vec;
    logic               run;

    // Purpose: falling-edge strobe of the oscillator clock.
    opg_edge_sync #(.STAGES(SYNC_STAGES), .DETECT_FALL(1'b1)) osc_sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    (osc_clk_i),
        .edge_o (osc_fall)
    );

    // Purpose: one synchronizer and pulse checker per comparator.
    generate
        for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
            opg_edge_sync #(.STAGES(SYNC_STAGES), .DETECT_FALL(1'b0)) cmp_sync_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .d_i    (cmp_i[g]),
                .edge_o (cmp_rise[g])
            );
            opg_pulse_check chk_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .en_i       (run),
                .cmp_rise_i (cmp_rise[g]),
                .osc_fall_i (osc_fall),
                .fault_o    (fault_vec[g])
            );
        end
    endgenerate

    opg_rst_seq #(.HOLD_W(HOLD_W), .GAP_CYCLES(GAP_CYCLES)) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault_i      (|fault_vec),
        .hold_len_i   (hold_len_i),
        .rst_bias_n_o (rst_bias_n_o),
        .rst_chg_n_o  (rst_chg_n_o),
        .rst_clk_n_o  (rst_clk_n_o),
        .run_o        (run)
    );

    opg_fault_log #(.NUM_CMP(NUM_CMP), .CNT_W(CNT_W)) log_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .fault_vec_i   (fault_vec),
        .fault_seen_o  (fault_seen_o),
        .fault_count_o (fault_count_o)
    );

    // R6: a checker only reports while the oscillator is fully released.
    a_r6_fault_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_vec) |-> rst_clk_n_o);

endmodule

// File: tb/osc_pulse_guard_tb_top.sv
// Bench: a behavioural two-phase oscillator drives the guard; a vector table
// of hold lengths and dropped-pulse patterns is walked, then directed tests.
module osc_pulse_guard_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 4;
    localparam int CNT_MAX    = 15;
    localparam int NV         = 8;
    // Fields: [13:6] hold length, [5:2] dropped pulses {B2,B1,A2,A1}, [1:0] expected source.
    localparam logic [13:0] VEC [NV] = '{
        {8'd5,  4'b0000, 2'b00},
        {8'd5,  4'b0010, 2'b01},
        {8'd3,  4'b0100, 2'b10},
        {8'd0,  4'b0001, 2'b01},
        {8'd12, 4'b1000, 2'b10},
        {8'd7,  4'b0101, 2'b11},
        {8'd2,  4'b1111, 2'b11},
        {8'd9,  4'b0000, 2'b00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_clk = 1'b0;
    logic [1:0] cmp = 2'b00;
    logic [7:0] hold_len = 8'd5;
    logic       rst_bias_n, rst_chg_n, rst_clk_n;
    logic [1:0] fault_seen;
    logic [3:0] fault_count;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int events = 0;
    int exp_events = 0;
    logic [3:0] drop_req = 4'b0000;
    logic [1:0] acc_src = 2'b00;

    osc_pulse_guard dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .osc_clk_i     (osc_clk),
        .cmp_i         (cmp),
        .hold_len_i    (hold_len),
        .rst_bias_n_o  (rst_bias_n),
        .rst_chg_n_o   (rst_chg_n),
        .rst_clk_n_o   (rst_clk_n),
        .fault_seen_o  (fault_seen),
        .fault_count_o (fault_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Oscillator model: 16 clk periods per cycle, runs only while released.
    initial begin
        logic [3:0] pat;
        bit ok;
        forever begin
            @(negedge clk);
            if (rst_clk_n === 1'b1) begin
                pat = drop_req;
                drop_req = 4'b0000;
                ok = 1'b1;
                for (int i = 0; i < 16; i++) begin
                    if (rst_clk_n !== 1'b1) begin
                        ok = 1'b0;
                        break;
                    end
                    osc_clk = (i < 8);
                    cmp[0] = ((i == 1 || i == 2) && !pat[0]) || ((i == 10 || i == 11) && !pat[1]);
                    cmp[1] = ((i == 3 || i == 4) && !pat[2]) || ((i == 12 || i == 13) && !pat[3]);
                    @(negedge clk);
                end
                osc_clk = 1'b0;
                cmp = 2'b00;
                if (ok) cyc++;
            end
        end
    end

    // Count falling edges of the bias reset seen at the port.
    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (prev === 1'b1 && rst_bias_n === 1'b0) events++;
            prev = rst_bias_n;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic measure(output int lo, output int g1, output int g2, output int together);
        int t = 0;
        while (rst_bias_n !== 1'b0 && t < 300) begin @(negedge clk); t++; end
        together = (rst_chg_n === 1'b0 && rst_clk_n === 1'b0) ? 1 : 0;
        lo = 0; g1 = 0; g2 = 0;
        while (rst_bias_n === 1'b0 && lo < 300) begin lo++; @(negedge clk); end
        while (rst_chg_n === 1'b0 && g1 < 300) begin g1++; @(negedge clk); end
        while (rst_clk_n === 1'b0 && g2 < 300) begin g2++; @(negedge clk); end
    endtask

    task automatic run_cycles(input int n);
        int s = cyc;
        int t = 0;
        while (cyc < s + n && t < 2000) begin @(negedge clk); t++; end
    endtask

    task automatic inject(input logic [3:0] pat);
        @(posedge clk);
        drop_req = pat;
        @(negedge clk);
    endtask

    initial begin
        int lo, g1, g2, tog, eff;
        logic [7:0] h;
        logic [3:0] pat;
        logic [1:0] src;

        // R1: reset state, then the power-on release sequence.
        repeat (5) @(negedge clk);
        check("R1", "bias reset in reset", int'(rst_bias_n), 0);
        check("R1", "charge reset in reset", int'(rst_chg_n), 0);
        check("R1", "clock hold in reset", int'(rst_clk_n), 0);
        check("R1", "sticky flags in reset", int'(fault_seen), 0);
        check("R1", "count in reset", int'(fault_count), 0);
        rst_n = 1'b1;
        measure(lo, g1, g2, tog);
        check("R1", "power-on hold length", lo, 5);
        check("R5", "power-on bias to charge gap", g1, GAP);
        check("R5", "power-on charge to clock gap", g2, GAP);

        // Vector table walk.
        for (int v = 0; v < NV; v++) begin
            h = VEC[v][13:6];
            pat = VEC[v][5:2];
            src = VEC[v][1:0];
            hold_len = h;
            run_cycles(2);
            inject(pat);
            if (src != 2'b00) begin
                eff = (h == 0) ? 1 : int'(h);
                measure(lo, g1, g2, tog);
                exp_events++;
                acc_src = acc_src | src;
                check("R3", $sformatf("vec%0d all resets low together", v), tog, 1);
                check("R4", $sformatf("vec%0d hold length", v), lo, eff);
                check("R5", $sformatf("vec%0d bias to charge gap", v), g1, GAP);
                check("R5", $sformatf("vec%0d charge to clock gap", v), g2, GAP);
            end else begin
                run_cycles(4);
                check("R2", $sformatf("vec%0d clock hold stays released", v), int'(rst_clk_n), 1);
            end
            // R6: no false fault after restart with cleared halving stages.
            run_cycles(3);
            check("R6", $sformatf("vec%0d reset events at port", v), events, exp_events);
            check("R7", $sformatf("vec%0d sticky flags", v), int'(fault_seen), int'(acc_src));
            check("R8", $sformatf("vec%0d event count", v), int'(fault_count), exp_events);
        end

        // R8: saturation of the event count.
        hold_len = 8'd1;
        for (int k = 0; k < 12; k++) begin
            run_cycles(1);
            inject(4'b0001);
            measure(lo, g1, g2, tog);
            exp_events++;
        end
        run_cycles(2);
        check("R8", "event count saturates", int'(fault_count), (exp_events > CNT_MAX) ? CNT_MAX : exp_events);
        check("R8", "port events after burst", events, exp_events);
        check("R7", "sticky flags after burst", int'(fault_seen), int'(acc_src));

        // R1: mid-run reset clears the log and restarts the sequence.
        hold_len = 8'd6;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1", "mid-run reset bias", int'(rst_bias_n), 0);
        check("R1", "mid-run reset clock hold", int'(rst_clk_n), 0);
        check("R7", "sticky flags cleared by reset", int'(fault_seen), 0);
        check("R8", "count cleared by reset", int'(fault_count), 0);
        rst_n = 1'b1;
        measure(lo, g1, g2, tog);
        check("R4", "hold after mid-run reset", lo, 6);
        check("R5", "gaps after mid-run reset", g1 + g2, 2 * GAP);
        run_cycles(3);
        check("R2", "clean running after reset", int'(fault_count), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule